// File: doc/BRIEF.md
# Reset Release Warm-Up Sequencer

This block combines three reset requests: a power-on reset, an external reset pin and an internal reset request from on-chip supervisors. While any request is active it holds the CPU and the peripherals in reset. Once every request has gone away, a two-flop chain brings the release into the clock domain. The block then times a warm-up period on the high-frequency clock and uses it to read one trim byte from a non-volatile store. After warm-up it fetches the 16-bit start address, low byte first, from two adjacent vector locations, and only then lets the CPU out of reset.

The trim byte carries its own check: its eight bits must hold an odd number of ones. A byte that fails this check sets a fault flag. The flag is cleared only by a power-on or external reset, so it still shows the failure after an internal reset. If any reset request arrives during warm-up or the vector fetch, the whole sequence starts again from zero.

Top module: `rst_warmup_seq`

## Requirements
- R1: While por_n is low, ext_rst_n is low or int_rst_req is high, cpu_rst_n and periph_rst_n are low, without waiting for a clock edge.
- R2: periph_rst_n goes high at the second rising clock edge after the last reset request is removed.
- R3: With no further request, cpu_rst_n goes high at rising edge WARMUP_CYCLES+6 counted from the removal of the last request.
- R4: During warm-up the store is read exactly once at TRIM_ADDR (read data is returned one clock after mem_rd_en). trim_value then equals bits 6:0 of that byte, and trim_valid is high.
- R5: trim_fault is set when the trim byte has an even number of ones (an odd count is correct).
- R6: trim_fault is cleared only by por_n or ext_rst_n. An int_rst_req leaves it unchanged.
- R7: A reset request during warm-up restarts the sequence, so the release timing of R3 is counted again from the new removal.
- R8: reset_vector equals {byte at VEC_LO_ADDR+1, byte at VEC_LO_ADDR}, with VEC_LO_ADDR defaulting to 0xFFFE. vector_valid is high once it has been loaded.
- R9: cpu_rst_n is high only when trim_valid and vector_valid are high. It stays high, with a stable reset_vector, until the next reset request.
- R10: An int_rst_req raised while the CPU is running puts the CPU back in reset, and the full sequence runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| int_rst_req | input | 1 | Internal reset request, active high |
| mem_rd_en | output | 1 | Read strobe to the non-volatile store |
| mem_addr | output | 16 | Read address |
| mem_rd_data | input | 8 | Read data, valid one clock after the strobe |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| cpu_rst_n | output | 1 | CPU reset, active low |
| trim_value | output | 7 | Loaded trim setting |
| trim_valid | output | 1 | Trim byte loaded |
| trim_fault | output | 1 | Sticky trim check failure |
| reset_vector | output | 16 | CPU start address |
| vector_valid | output | 1 | Start address loaded |

## Verification
The assertions rely on two things. The store answers every strobe with data exactly one clock later, and WARMUP_CYCLES is at least two, so the trim read finishes inside the warm-up window. The bench's store model is a single registered read stage, and it uses a warm-up length of ten. Every reset request is changed on a falling edge and is held for at least one full clock, so the release chain always sees a clean level.

// File: rtl/rst_warmup_seq.sv
module rst_warmup_seq #(
  parameter int          WARMUP_CYCLES = 16,
  parameter logic [15:0] TRIM_ADDR     = 16'h0FC0,
  parameter logic [15:0] VEC_LO_ADDR   = 16'hFFFE
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        ext_rst_n,
  input  logic        int_rst_req,
  output logic        mem_rd_en,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rd_data,
  output logic        periph_rst_n,
  output logic        cpu_rst_n,
  output logic [6:0]  trim_value,
  output logic        trim_valid,
  output logic        trim_fault,
  output logic [15:0] reset_vector,
  output logic        vector_valid
);
  localparam int          CW          = $clog2(WARMUP_CYCLES + 1);
  localparam logic [15:0] VEC_HI_ADDR = VEC_LO_ADDR + 16'd1;
  localparam logic [CW-1:0] CNT_LAST  = CW'(WARMUP_CYCLES - 1);

  typedef enum logic [1:0] {S_RESET, S_WARMUP, S_VECTOR, S_RUN} state_t;

  logic          hard_rst_n, any_rst_n, released, trim_cap;
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt;
  logic [1:0]    vstep;
  state_t        state;

  assign hard_rst_n   = por_n & ext_rst_n;
  assign any_rst_n    = hard_rst_n & ~int_rst_req;
  assign released     = sync_q[1];
  assign periph_rst_n = released & any_rst_n;
  assign cpu_rst_n    = (state == S_RUN) & any_rst_n;
  assign trim_cap     = (state == S_WARMUP) && (cnt == CW'(1));

  assign mem_rd_en = ((state == S_WARMUP) && (cnt == '0)) ||
                     ((state == S_VECTOR) && (vstep != 2'd2));
  assign mem_addr  = (state == S_WARMUP) ? TRIM_ADDR :
                     (vstep == 2'd0)     ? VEC_LO_ADDR : VEC_HI_ADDR;

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) sync_q <= 2'b00;
    else            sync_q <= {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) begin
      state        <= S_RESET;
      cnt          <= '0;
      vstep        <= 2'd0;
      trim_value   <= '0;
      trim_valid   <= 1'b0;
      reset_vector <= '0;
      vector_valid <= 1'b0;
    end else begin
      case (state)
        S_RESET: if (released) begin
          state <= S_WARMUP;
          cnt   <= '0;
        end
        S_WARMUP: begin
          if (trim_cap) begin
            trim_value <= mem_rd_data[6:0];
            trim_valid <= 1'b1;
          end
          if (cnt == CNT_LAST) begin
            state <= S_VECTOR;
            vstep <= 2'd0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_VECTOR: begin
          if (vstep == 2'd1) reset_vector[7:0] <= mem_rd_data;
          if (vstep == 2'd2) begin
            reset_vector[15:8] <= mem_rd_data;
            vector_valid       <= 1'b1;
            state              <= S_RUN;
          end else begin
            vstep <= vstep + 2'd1;
          end
        end
        default: state <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n)                   trim_fault <= 1'b0;
    else if (trim_cap && !(^mem_rd_data)) trim_fault <= 1'b1;
  end

  AST_RUN_NEEDS_LOADS: assert property (@(posedge clk) disable iff (!any_rst_n)
    cpu_rst_n |-> (trim_valid && vector_valid)); // R9
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!any_rst_n)
    cpu_rst_n |=> (cpu_rst_n && $stable(reset_vector))); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!any_rst_n)
    (state == S_WARMUP) |-> (cnt < CW'(WARMUP_CYCLES))); // R3
  AST_PERIPH_BEFORE_CPU: assert property (@(posedge clk) disable iff (!any_rst_n)
    cpu_rst_n |-> periph_rst_n); // R2
  AST_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (!any_rst_n)
    mem_rd_en |-> (!cpu_rst_n && periph_rst_n)); // R4
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $past(trim_fault) |-> trim_fault); // R6
endmodule

// File: tb/tb_rst_warmup_seq.sv
module tb_rst_warmup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 10;
  localparam logic [15:0] TA = 16'h0FC0;

  logic clk = 0, por_n = 0, ext_rst_n = 1, int_rst_req = 0;
  logic mem_rd_en, periph_rst_n, cpu_rst_n, trim_valid, trim_fault, vector_valid;
  logic [15:0] mem_addr, reset_vector;
  logic [7:0]  mem_rd_data = 0, m_trim = 0, m_lo = 0, m_hi = 0;
  logic [6:0]  trim_value;
  int checks = 0, fails = 0, trim_reads = 0;

  rst_warmup_seq #(.WARMUP_CYCLES(W), .TRIM_ADDR(TA)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (mem_rd_en) begin
    if (mem_addr == TA) trim_reads <= trim_reads + 1;
    mem_rd_data <= (mem_addr == TA) ? m_trim : (mem_addr == 16'hFFFE) ? m_lo :
                   (mem_addr == 16'hFFFF) ? m_hi : 8'h00;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_seq(output int n);
    n = 0;
    while (!cpu_rst_n && n < 1000) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  task automatic por_release;
    @(negedge clk); por_n = 0; trim_reads = 0;
    @(negedge clk); por_n = 1;
  endtask

  localparam logic [31:0] TBL [4] = '{
    {8'h01, 8'h34, 8'h12, 8'h00},
    {8'h03, 8'hCD, 8'hAB, 8'h01},
    {8'hFE, 8'h00, 8'h80, 8'h00},
    {8'h00, 8'hFF, 8'hFF, 8'h01}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    #(CLK_PERIOD * 3 + 1);
    chk("R1 reset cpu", cpu_rst_n, 0);
    chk("R1 reset periph", periph_rst_n, 0);
    chk("R1 reset fault", trim_fault, 0);

    for (int i = 0; i < 4; i++) begin
      {m_trim, m_lo, m_hi} = TBL[i][31:8];
      por_release();
      run_seq(n);
      chk("R3 release cycles", n, W + 6);
      chk("R8 vector", reset_vector, {m_hi, m_lo});
      chk("R8 vector_valid", vector_valid, 1);
      chk("R4 trim_value", {trim_valid, trim_value}, {1'b1, m_trim[6:0]});
      chk("R4 trim reads", trim_reads, 1);
      chk("R5 parity fault", trim_fault, TBL[i][0]);
      chk("R9 loads before run", {trim_valid, vector_valid}, 2'b11);
    end

    @(negedge clk); por_n = 0; trim_reads = 0;
    @(negedge clk); por_n = 1;
    chk("R2 periph after 0", periph_rst_n, 0);
    @(posedge clk); @(negedge clk);
    chk("R2 periph after 1", periph_rst_n, 0);
    @(posedge clk); @(negedge clk);
    chk("R2 periph after 2", periph_rst_n, 1);
    run_seq(n);

    m_trim = 8'h03;
    por_release(); run_seq(n);
    chk("R5 fault set", trim_fault, 1);
    m_trim = 8'h01;
    @(negedge clk); int_rst_req = 1; #1;
    chk("R10 cpu held", cpu_rst_n, 0);
    chk("R1 periph held", periph_rst_n, 0);
    chk("R6 fault kept on internal", trim_fault, 1);
    @(negedge clk); int_rst_req = 0; trim_reads = 0;
    run_seq(n);
    chk("R10 rerun cycles", n, W + 6);
    chk("R6 fault still set", trim_fault, 1);
    chk("R4 new trim", trim_value, 7'h01);
    @(negedge clk); ext_rst_n = 0; #1;
    chk("R6 ext clears fault", trim_fault, 0);
    chk("R1 ext holds cpu", cpu_rst_n, 0);
    @(negedge clk); ext_rst_n = 1;
    run_seq(n);
    chk("R6 fault clear after good trim", trim_fault, 0);

    m_lo = 8'h5A; m_hi = 8'hC3;
    por_release();
    repeat (6) begin @(posedge clk); @(negedge clk); end
    chk("R7 mid warmup", cpu_rst_n, 0);
    int_rst_req = 1; #1;
    chk("R7 periph reasserted", periph_rst_n, 0);
    @(negedge clk); int_rst_req = 0; trim_reads = 0;
    run_seq(n);
    chk("R7 restart cycles", n, W + 6);
    chk("R7 one trim read", trim_reads, 1);
    chk("R8 vector after restart", reset_vector, 16'hC35A);
    repeat (5) begin @(posedge clk); @(negedge clk); end
    chk("R9 stays running", {cpu_rst_n, reset_vector}, {1'b1, 16'hC35A});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule